// File: doc/BRIEF.md
# Memory-to-Cipher Stream Sequencer

This block sits between two block RAMs and a streaming authenticated cipher core. It owns the A-side address of the input RAM, which feeds the core, and the A-side address and write strobe of the output RAM, which collects the core's results. Each RAM word is 128 bits, and one address holds one cipher block.

A run begins when the register file sends a one-cycle start pulse. That pulse comes from the write of the data-length register. On the start pulse, both address counters load their starting values. From then on, the input address steps once for every block the core reads, first the associated data and then the payload. Every result block the core emits is written to the output RAM at the current output address, and that address then steps by one.

When the core flags its authentication tag as valid, the tag is latched into a holding register. The run ends on the tag. In pass-through mode no tag is produced, so the run ends instead when the number of written blocks equals the payload byte count divided by 16 and rounded up. While a run is in progress, the busy output is high.

Top module: `cipher_stream_seq`

## Requirements
- R1: After reset, `busy` is 0, `outRamWrEn` is 0, both RAM addresses are 0 and `tagHold` is 0.
- R2: A `startPulse` seen while idle loads `inRamAddr` from `inBaseAddr` and `outRamAddr` from `outBaseAddr`, and `busy` reads 1 from the following cycle.
- R3: While busy, `inRamAddr` increases by one after every cycle in which `coreRdStrobe` is 1, and it holds otherwise.
- R4: While busy, a cycle with `coreOutValid` = 1 drives `outRamWrEn` = 1 in that same cycle, with `outRamWrData` = `coreOutData` at the current `outRamAddr`. `outRamAddr` then increases by one.
- R5: While busy in cipher mode (`bypassMode` = 0 at start), `tagHold` takes `coreTag` on the cycle `coreTagValid` is 1 and keeps its value at all other times.
- R6: In cipher mode, `busy` falls in the cycle after the one in which `coreTagValid` is 1.
- R7: In pass-through mode (`bypassMode` = 1 at start), `busy` falls in the cycle after output block number ceil(`dataBytes`/16) is written. With `dataBytes` = 0, `busy` is high for exactly one cycle. `tagHold` does not change during the run.
- R8: A `startPulse` that arrives while busy has no effect: neither address reloads and the run continues.
- R9: While idle, `coreRdStrobe` and `coreOutValid` have no effect: no write strobe is issued and neither address moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-cycle run launch from the data-length register write |
| bypassMode | input | 1 | 1 selects pass-through (no tag); sampled at start |
| dataBytes | input | LW (16) | Payload length in bytes; sampled at start |
| inBaseAddr | input | AW (7) | Starting block address for the input RAM |
| outBaseAddr | input | AW (7) | Starting block address for the output RAM |
| coreRdStrobe | input | 1 | Core consumed the block at the current input address |
| coreOutValid | input | 1 | Core result block valid |
| coreOutData | input | 128 | Core result block |
| coreTagValid | input | 1 | Core authentication tag valid |
| coreTag | input | 128 | Core authentication tag |
| inRamAddr | output | AW (7) | Input RAM port A block address |
| outRamAddr | output | AW (7) | Output RAM port A block address |
| outRamWrEn | output | 1 | Output RAM port A write strobe |
| outRamWrData | output | 128 | Output RAM port A write data |
| tagHold | output | 128 | Latched authentication tag |
| busy | output | 1 | Run in progress |

## Verification
The hardest case to reach from the ports is the end of a pass-through run. Busy must drop exactly after the block whose index equals the rounded-up byte count, not one block early or late. The stimulus uses a length that is not a multiple of 16 and checks busy after the second-to-last block and again after the last. A zero-length pass-through run is added, because it must end without any output block. A start pulse is also injected partway through a cipher run, and the addresses are checked to show that neither counter reloaded.

// File: rtl/cipher_stream_seq_pkg.sv
package cipher_stream_seq_pkg;
  localparam int BLK_W = 128;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seqState_t;

  typedef struct packed {
    logic loadAddr;
    logic incIn;
    logic incOut;
    logic captureTag;
  } seqCtl_t;
endpackage

// File: rtl/cipher_stream_seq_ctrl.sv
module cipher_stream_seq_ctrl
  import cipher_stream_seq_pkg::*;
#(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startPulse,
  input  logic          bypassMode,
  input  logic [LW-1:0] dataBytes,
  input  logic          coreRdStrobe,
  input  logic          coreOutValid,
  input  logic          coreTagValid,
  output seqCtl_t       ctl,
  output logic          busy
);
  localparam int BW = LW - 3;

  seqState_t      state;
  logic           bypassLat;
  logic [BW-1:0]  targetBlocks;
  logic [BW-1:0]  blockCnt;
  logic [LW:0]    roundedBytes;
  logic           running;
  logic           doneNow;
  logic           lastBlock;

  assign running      = (state == ST_RUN);
  assign roundedBytes = {1'b0, dataBytes} + (LW+1)'(15);
  assign lastBlock    = coreOutValid && ((blockCnt + 1'b1) == targetBlocks);
  assign doneNow      = running && (bypassLat ? ((targetBlocks == '0) || lastBlock)
                                              : coreTagValid);

  always_comb begin
    ctl.loadAddr   = !running && startPulse;
    ctl.incIn      = running && coreRdStrobe;
    ctl.incOut     = running && coreOutValid;
    ctl.captureTag = running && !bypassLat && coreTagValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      bypassLat    <= 1'b0;
      targetBlocks <= '0;
      blockCnt     <= '0;
    end else if (!running) begin
      if (startPulse) begin
        state        <= ST_RUN;
        bypassLat    <= bypassMode;
        targetBlocks <= roundedBytes[LW:4];
        blockCnt     <= '0;
      end
    end else begin
      if (coreOutValid) blockCnt <= blockCnt + 1'b1;
      if (doneNow) state <= ST_IDLE;
    end
  end

  assign busy = running;

  // R2: a run only begins from an idle start pulse
  assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startPulse));

  // R8: a start pulse during a run that is not ending leaves it running
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startPulse && !coreTagValid && !coreOutValid && !bypassLat) |=> busy);

  // R6: in cipher mode the tag ends the run
  assert_tag_ends_run_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !bypassLat && coreTagValid) |=> !busy);
endmodule

// File: rtl/cipher_stream_seq_dp.sv
module cipher_stream_seq_dp
  import cipher_stream_seq_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCtl_t          ctl,
  input  logic [AW-1:0]    inBaseAddr,
  input  logic [AW-1:0]    outBaseAddr,
  input  logic [BLK_W-1:0] coreOutData,
  input  logic [BLK_W-1:0] coreTag,
  output logic [AW-1:0]    inRamAddr,
  output logic [AW-1:0]    outRamAddr,
  output logic             outRamWrEn,
  output logic [BLK_W-1:0] outRamWrData,
  output logic [BLK_W-1:0] tagHold
);
  logic [AW-1:0] inAddr;
  logic [AW-1:0] outAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inAddr  <= '0;
      outAddr <= '0;
    end else if (ctl.loadAddr) begin
      inAddr  <= inBaseAddr;
      outAddr <= outBaseAddr;
    end else begin
      if (ctl.incIn)  inAddr  <= inAddr + 1'b1;
      if (ctl.incOut) outAddr <= outAddr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               tagHold <= '0;
    else if (ctl.captureTag) tagHold <= coreTag;
  end

  assign inRamAddr    = inAddr;
  assign outRamAddr   = outAddr;
  assign outRamWrEn   = ctl.incOut;
  assign outRamWrData = coreOutData;

  // R3: input address steps once per consumed block
  assert_in_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.incIn && !ctl.loadAddr) |=> inAddr == $past(inAddr) + 1'b1);

  // R4: output address steps after each written block, else holds
  assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.loadAddr && !ctl.incOut) |=> $stable(outAddr));

  // R5: held tag changes only on a capture
  assert_tag_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.captureTag |=> $stable(tagHold));
endmodule

// File: rtl/cipher_stream_seq.sv
module cipher_stream_seq
  import cipher_stream_seq_pkg::*;
#(
  parameter int AW = 7,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startPulse,
  input  logic          bypassMode,
  input  logic [LW-1:0] dataBytes,
  input  logic [AW-1:0] inBaseAddr,
  input  logic [AW-1:0] outBaseAddr,
  input  logic          coreRdStrobe,
  input  logic          coreOutValid,
  input  logic [127:0]  coreOutData,
  input  logic          coreTagValid,
  input  logic [127:0]  coreTag,
  output logic [AW-1:0] inRamAddr,
  output logic [AW-1:0] outRamAddr,
  output logic          outRamWrEn,
  output logic [127:0]  outRamWrData,
  output logic [127:0]  tagHold,
  output logic          busy
);
  seqCtl_t ctl;

  cipher_stream_seq_ctrl #(.LW(LW)) ctrl_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .bypassMode(bypassMode),
    .dataBytes(dataBytes), .coreRdStrobe(coreRdStrobe), .coreOutValid(coreOutValid),
    .coreTagValid(coreTagValid), .ctl(ctl), .busy(busy)
  );

  cipher_stream_seq_dp #(.AW(AW)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inBaseAddr(inBaseAddr),
    .outBaseAddr(outBaseAddr), .coreOutData(coreOutData), .coreTag(coreTag),
    .inRamAddr(inRamAddr), .outRamAddr(outRamAddr), .outRamWrEn(outRamWrEn),
    .outRamWrData(outRamWrData), .tagHold(tagHold)
  );

  // R9: no write strobe outside a run
  assert_no_idle_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    outRamWrEn |-> busy);
endmodule

// File: tb/cipher_stream_seq_tb_top.sv
module cipher_stream_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 7;
  localparam int LW = 16;

  typedef struct {
    logic [AW-1:0] addr;
    logic [127:0]  data;
  } wrItem_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startPulse = 1'b0, bypassMode = 1'b0;
  logic [LW-1:0] dataBytes = '0;
  logic [AW-1:0] inBaseAddr = '0, outBaseAddr = '0;
  logic          coreRdStrobe = 1'b0, coreOutValid = 1'b0, coreTagValid = 1'b0;
  logic [127:0]  coreOutData = '0, coreTag = '0;
  logic [AW-1:0] inRamAddr, outRamAddr;
  logic          outRamWrEn, busy;
  logic [127:0]  outRamWrData, tagHold;

  int      nChecks = 0;
  int      nFails = 0;
  wrItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cipher_stream_seq #(.AW(AW), .LW(LW)) dut_i (.*);

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic startRun(input logic byp, input logic [LW-1:0] len,
                          input logic [AW-1:0] ib, input logic [AW-1:0] ob);
    bypassMode = byp; dataBytes = len; inBaseAddr = ib; outBaseAddr = ob;
    startPulse = 1'b1;
    cyc();
    startPulse = 1'b0;
  endtask

  task automatic sendOut(input logic [127:0] d, input logic [AW-1:0] a);
    wrItem_t it;
    it.addr = a; it.data = d;
    expQ.push_back(it);
    coreOutValid = 1'b1; coreOutData = d;
    cyc();
    coreOutValid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && outRamWrEn) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R4/R9 unexpected write", {121'b0, outRamAddr}, 0);
      end else begin
        wrItem_t e;
        e = expQ.pop_front();
        check(outRamAddr == e.addr, "R4 write addr", {121'b0, outRamAddr}, {121'b0, e.addr});
        check(outRamWrData == e.data, "R4 write data", outRamWrData, e.data);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();
    // R1 reset state
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(outRamWrEn == 1'b0, "R1 wren", outRamWrEn, 0);
    check(inRamAddr == 0 && outRamAddr == 0, "R1 addrs", {inRamAddr, outRamAddr}, 0);
    check(tagHold == 0, "R1 tag", tagHold, 0);

    // R9 strobes while idle
    coreRdStrobe = 1'b1; coreOutValid = 1'b1; coreOutData = 128'hdead;
    cyc();
    coreRdStrobe = 1'b0; coreOutValid = 1'b0;
    check(inRamAddr == 0, "R9 in addr idle", inRamAddr, 0);
    check(outRamAddr == 0, "R9 out addr idle", outRamAddr, 0);

    // R2 cipher run, 2 AAD blocks + 3 payload blocks (40 bytes)
    startRun(1'b0, 16'd40, 7'd3, 7'd5);
    check(busy == 1'b1, "R2 busy rise", busy, 1);
    check(inRamAddr == 7'd3, "R2 in base", inRamAddr, 3);
    check(outRamAddr == 7'd5, "R2 out base", outRamAddr, 5);
    for (int k = 1; k <= 5; k++) begin
      coreRdStrobe = 1'b1;
      cyc();
      coreRdStrobe = 1'b0;
      check(inRamAddr == 7'(3 + k), "R3 in step", inRamAddr, 3 + k);
    end
    cyc();
    check(inRamAddr == 7'd8, "R3 in hold", inRamAddr, 8);
    sendOut(128'h1111_0000_0000_0001, 7'd5);
    check(outRamAddr == 7'd6, "R4 out step", outRamAddr, 6);
    // R8 start mid-run
    startRun(1'b1, 16'd0, 7'd60, 7'd70);
    check(busy == 1'b1, "R8 still busy", busy, 1);
    check(inRamAddr == 7'd8 && outRamAddr == 7'd6, "R8 no reload",
          {inRamAddr, outRamAddr}, {7'd8, 7'd6});
    sendOut(128'h2222, 7'd6);
    sendOut(128'h3333_4444, 7'd7);
    check(busy == 1'b1, "R6 busy before tag", busy, 1);
    coreTagValid = 1'b1; coreTag = 128'hA5A5_0123_4567_89AB_CDEF_FEDC_BA98_7654;
    cyc();
    coreTagValid = 1'b0; coreTag = '0;
    check(busy == 1'b0, "R6 busy fall", busy, 0);
    check(tagHold == 128'hA5A5_0123_4567_89AB_CDEF_FEDC_BA98_7654, "R5 tag capture",
          tagHold, 128'hA5A5_0123_4567_89AB_CDEF_FEDC_BA98_7654);
    cyc();
    check(tagHold == 128'hA5A5_0123_4567_89AB_CDEF_FEDC_BA98_7654, "R5 tag held",
          tagHold, 128'hA5A5_0123_4567_89AB_CDEF_FEDC_BA98_7654);

    // R9 write after done
    coreOutValid = 1'b1;
    #2;
    check(outRamWrEn == 1'b0, "R9 no write after done", outRamWrEn, 0);
    cyc();
    coreOutValid = 1'b0;

    // R7 pass-through, 33 bytes -> 3 blocks
    startRun(1'b1, 16'd33, 7'd0, 7'd126);
    sendOut(128'hB1, 7'd126);
    sendOut(128'hB2, 7'd127);
    check(busy == 1'b1, "R7 busy before last", busy, 1);
    sendOut(128'hB3, 7'd0);
    check(busy == 1'b0, "R7 busy fall at ceil", busy, 0);
    check(tagHold == 128'hA5A5_0123_4567_89AB_CDEF_FEDC_BA98_7654, "R7 tag untouched",
          tagHold, 128'hA5A5_0123_4567_89AB_CDEF_FEDC_BA98_7654);

    // R7 zero-length pass-through
    startRun(1'b1, 16'd0, 7'd9, 7'd9);
    check(busy == 1'b1, "R7 zero len busy", busy, 1);
    cyc();
    check(busy == 1'b0, "R7 zero len end", busy, 0);

    repeat (2) cyc();
    check(expQ.size() == 0, "R4 all writes seen", expQ.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule